// File: doc/BRIEF.md
# Multi-Phase Numerically Controlled Clock Oscillator

This block synthesizes a digital square-wave clock whose average frequency is M x f_sys / 2^n. It does this by adding a jump size M to an n-bit phase accumulator on every system clock. One bit of the accumulator is taken as the clock value.

To get finer time resolution than one system clock period, the block forms eight phase points per cycle. Each point sits a further floor(M/8) beyond the previous one. The chosen bit of each point becomes one bit of an 8-bit word. An external serializer shifts that word out, bit 0 first in time.

The jump size can be nudged at run time, one step up or down, by requests from another clock domain. A request consists of a level-held enable bit, a direction bit and a control strobe. The strobe passes through a two-flop synchronizer. Each rising edge of the synchronized strobe moves M by exactly one step. The step stays within configured lower and upper limits and never wraps.

Top module: `multiphase_nco`

## Requirements
- R1: With CLK_BIT = ACC_W-1, word bit 0 rises once every 2^ACC_W / M system cycles. For example, with ACC_W = 8 and M = 16 it rises once every 16 cycles.
- R2: Word bit k is set in the word registered at an edge exactly when bit CLK_BIT of (base + k*floor(M/8)) mod 2^ACC_W is set. Here base and M are the values held before that edge. Bit 0 is the earliest sample in time.
- R3: The base accumulator advances by M, modulo 2^ACC_W, on every system clock edge outside reset.
- R4: A lower CLK_BIT gives a proportionally higher frequency. For example, with ACC_W = 8, CLK_BIT = 5 and M = 16, word bit 0 rises once every 4 cycles.
- R5: While the synchronous reset is asserted, the output word is all zeros, jumpSize equals M_NOM and the base accumulator is cleared to 0.
- R6: Suppose reqStrobe rises while reqEnable is 1. Then jumpSize changes by exactly one step on the third system clock edge after the rise. The step is +1 when reqUp is 1 and -1 when reqUp is 0.
- R7: A strobe rise while reqEnable is 0 leaves jumpSize unchanged.
- R8: jumpSize never goes above M_MAX or below M_MIN. A request that would pass either limit leaves jumpSize at that limit.
- R9: A strobe held high for many cycles produces only one step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqStrobe | input | 1 | Control strobe of a step request, asynchronous to clk |
| reqEnable | input | 1 | Request enable, held stable around the strobe |
| reqUp | input | 1 | Step direction: 1 raises M, 0 lowers it |
| laneWord | output | LANES | Clock samples for one system cycle, bit 0 earliest |
| jumpSize | output | ACC_W | Current jump size M |

## Verification
A corrupted base accumulator or lane offset shows up in laneWord on the very next cycle. This is because every registered word is a pure function of the base and M held one edge earlier. A wrong M update shows on jumpSize exactly three edges after the strobe rise, and its effect reaches laneWord one cycle later. Edge-detect or saturation faults show as a second step from a held strobe, or as jumpSize stepping past a limit. The frequency checks count rising edges over a fixed window. An error in bit selection or in the accumulator step therefore changes the count by whole edges.

// File: rtl/mpnco_pkg.sv
package mpnco_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepCmd_t;
endpackage

// File: rtl/nco_step_sync.sv
module nco_step_sync
  import mpnco_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     reqStrobe,
  input  logic     reqEnable,
  input  logic     reqUp,
  output stepCmd_t cmd
);
  logic [SYNC_STAGES:0] chain;
  logic                 riseSeen;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], reqStrobe};
  end

  assign riseSeen     = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign cmd.stepUp   = riseSeen & reqEnable & reqUp;
  assign cmd.stepDown = riseSeen & reqEnable & ~reqUp;

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.stepUp || cmd.stepDown) |=> !(cmd.stepUp || cmd.stepDown));
endmodule

// File: rtl/nco_phase_bank.sv
module nco_phase_bank
  import mpnco_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int LANES   = 8,
  parameter int CLK_BIT = ACC_W - 1,
  parameter int M_NOM   = 2048,
  parameter int M_MIN   = 1024,
  parameter int M_MAX   = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  stepCmd_t         cmd,
  output logic [LANES-1:0] laneWord,
  output logic [ACC_W-1:0] jumpSize
);
  localparam int LANE_SH = $clog2(LANES);
  localparam logic [ACC_W-1:0] JNOM = ACC_W'(M_NOM);
  localparam logic [ACC_W-1:0] JMIN = ACC_W'(M_MIN);
  localparam logic [ACC_W-1:0] JMAX = ACC_W'(M_MAX);

  logic [ACC_W-1:0] baseAcc;
  logic [ACC_W-1:0] jumpReg;
  logic [ACC_W-1:0] jumpNext;
  logic [ACC_W-1:0] laneGap;
  logic [ACC_W-1:0] laneVal [LANES];
  logic [LANES-1:0] laneBits;

  always_comb begin
    jumpNext = jumpReg;
    if (cmd.stepUp && (jumpReg < JMAX))        jumpNext = jumpReg + 1'b1;
    else if (cmd.stepDown && (jumpReg > JMIN)) jumpNext = jumpReg - 1'b1;
  end

  assign laneGap = jumpReg >> LANE_SH;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneVal[k]  = baseAcc + laneGap * ACC_W'(k);
    assign laneBits[k] = laneVal[k][CLK_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAcc  <= '0;
      jumpReg  <= JNOM;
      laneWord <= '0;
    end else begin
      baseAcc  <= baseAcc + jumpReg;
      jumpReg  <= jumpNext;
      laneWord <= laneBits;
    end
  end

  assign jumpSize = jumpReg;

  // R8
  jump_range_chk: assert property (@(posedge clk) disable iff (rst)
    (jumpReg >= JMIN) && (jumpReg <= JMAX));

  // R6
  unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(jumpReg) || (jumpReg == $past(jumpReg) + 1'b1) ||
    (jumpReg == $past(jumpReg) - 1'b1));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd.stepUp || cmd.stepDown) |=> $stable(jumpReg));
endmodule

// File: rtl/multiphase_nco.sv
module multiphase_nco
  import mpnco_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int LANES       = 8,
  parameter int CLK_BIT     = ACC_W - 1,
  parameter int M_NOM       = 2048,
  parameter int M_MIN       = 1024,
  parameter int M_MAX       = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqStrobe,
  input  logic             reqEnable,
  input  logic             reqUp,
  output logic [LANES-1:0] laneWord,
  output logic [ACC_W-1:0] jumpSize
);
  stepCmd_t cmd;

  nco_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .reqStrobe(reqStrobe),
    .reqEnable(reqEnable), .reqUp(reqUp), .cmd(cmd)
  );

  nco_phase_bank #(
    .ACC_W(ACC_W), .LANES(LANES), .CLK_BIT(CLK_BIT),
    .M_NOM(M_NOM), .M_MIN(M_MIN), .M_MAX(M_MAX)
  ) u_bank (
    .clk(clk), .rst(rst), .cmd(cmd),
    .laneWord(laneWord), .jumpSize(jumpSize)
  );
endmodule

// File: tb/sim_multiphase_nco.sv
module sim_multiphase_nco;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqStrobe = 1'b0, reqEnable = 1'b0, reqUp = 1'b0;
  logic [7:0] word0, word1, jump0, jump1;
  int checks = 0, fails = 0;
  string tag = "R5";
  bit done = 1'b0;

  always #10 clk = ~clk;

  multiphase_nco #(.ACC_W(8), .LANES(8), .CLK_BIT(7), .M_NOM(16),
    .M_MIN(14), .M_MAX(18), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .reqStrobe(reqStrobe), .reqEnable(reqEnable),
    .reqUp(reqUp), .laneWord(word0), .jumpSize(jump0));

  multiphase_nco #(.ACC_W(8), .LANES(8), .CLK_BIT(5), .M_NOM(16),
    .M_MIN(14), .M_MAX(18), .SYNC_STAGES(2)) u1 (
    .clk(clk), .rst(rst), .reqStrobe(reqStrobe), .reqEnable(reqEnable),
    .reqUp(reqUp), .laneWord(word1), .jumpSize(jump1));

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic logic [7:0] laneBits(input logic [7:0] b, input logic [7:0] m, input int cb);
    logic [7:0] r, v;
    for (int k = 0; k < 8; k++) begin
      v = b + (m >> 3) * 8'(k);
      r[k] = v[cb];
    end
    return r;
  endfunction

  // scoreboard model: expected {word0, word1, jump} after each edge
  logic [23:0] expQ[$];
  logic [7:0] mBase, mM, nW0, nW1;
  logic s1, s2, s3, rise;
  always @(posedge clk) begin
    if (rst) begin
      mBase = 0; mM = 16; s1 = 0; s2 = 0; s3 = 0; nW0 = 0; nW1 = 0;
    end else begin
      nW0 = laneBits(mBase, mM, 7);
      nW1 = laneBits(mBase, mM, 5);
      rise = s2 && !s3;
      mBase = mBase + mM;
      if (rise && reqEnable) begin
        if (reqUp && mM < 18) mM = mM + 1;
        else if (!reqUp && mM > 14) mM = mM - 1;
      end
      s3 = s2; s2 = s1; s1 = reqStrobe;
    end
    expQ.push_back({nW0, nW1, mM});
  end

  // monitor
  always @(negedge clk) begin
    if (expQ.size() > 0 && !done) begin
      logic [23:0] e;
      e = expQ.pop_front();
      chk({tag, " R2 R3 word0"}, word0, e[23:16]);
      chk({tag, " R4 word1"}, word1, e[15:8]);
      chk({tag, " jump"}, jump0, e[7:0]);
    end
  end

  int expM = 16;

  task automatic pulse(input logic en, input logic up, input string t);
    int oldM, newM;
    oldM = expM;
    newM = oldM;
    if (en && up && oldM < 18) newM = oldM + 1;
    if (en && !up && oldM > 14) newM = oldM - 1;
    @(negedge clk);
    reqEnable = en; reqUp = up; reqStrobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk({t, " before third edge"}, jump0, oldM);
    @(negedge clk);
    chk({t, " after third edge"}, jump0, newM);
    repeat (2) @(negedge clk);
    reqStrobe = 1'b0;
    repeat (5) @(negedge clk);
    chk({t, " settled"}, jump0, newM);
    expM = newM;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0, r1;
    logic p0, p1;
    repeat (4) @(negedge clk);
    chk("R5 reset word", word0, 0);
    chk("R5 reset jump", jump0, 16);
    rst = 1'b0;
    tag = "R1";
    p0 = word0[0]; p1 = word1[0]; r0 = 0; r1 = 0;
    repeat (160) begin
      @(negedge clk);
      if (word0[0] && !p0) r0++;
      if (word1[0] && !p1) r1++;
      p0 = word0[0]; p1 = word1[0];
    end
    chk("R1 rises in 160 cycles", r0, 10);
    chk("R4 rises in 160 cycles", r1, 40);
    tag = "R6";
    pulse(1'b1, 1'b1, "R6 up");
    pulse(1'b1, 1'b0, "R6 down");
    tag = "R7";
    pulse(1'b0, 1'b1, "R7 disabled up");
    pulse(1'b0, 1'b0, "R7 disabled down");
    tag = "R8";
    repeat (3) pulse(1'b1, 1'b1, "R8 upper");
    chk("R8 at max", jump0, 18);
    repeat (6) pulse(1'b1, 1'b0, "R8 lower");
    chk("R8 at min", jump0, 14);
    tag = "R9";
    @(negedge clk);
    reqEnable = 1'b1; reqUp = 1'b1; reqStrobe = 1'b1;
    repeat (25) @(negedge clk);
    chk("R9 held strobe one step", jump0, 15);
    reqStrobe = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 after release", jump0, 15);
    tag = "R2";
    repeat (40) @(negedge clk);
    rst = 1'b1;
    tag = "R5";
    repeat (2) @(negedge clk);
    chk("R5 re-reset word", word0, 0);
    chk("R5 re-reset jump", jump0, 16);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule